// File: doc/BRIEF.md
# Inversionless Key Equation Iterator

This block carries out the inner loop of an inversion-free Berlekamp-Massey-type key-equation solver over GF(2^M) for one outer iteration of a burst-plus-random-error Reed-Solomon decoder. When `start` is taken, it loads eight coefficient vectors from three input polynomials: a scaled locator seed, a modified-syndrome polynomial and the raw syndromes. It also sets a scalar `gamma` to one and a signed counter `k` to zero. It then advances all eight vectors together, one iteration per clock, for `2*BETA` cycles. No field inversion is needed.

The data path holds four pairs of vectors. Two pairs are locator pairs: the main locator with its auxiliary, and the tilde locator with its auxiliary. The other two pairs are discrepancy pairs: the tilde discrepancy with its auxiliary, and the starred discrepancy with its auxiliary. In every iteration, the low coefficient of the tilde discrepancy vector (`d0`) is the discrepancy that drives all four pairs. After the last iteration the block raises `done` for one cycle. It then holds the two locator candidates and the two discrepancy-derived evaluator vectors for the position-tracking stage that follows, until the next `start`.

Top module: `ikes_iter`

## Requirements
- R1: While `rst_n` is low and after its release, all four output vectors read zero and `done` is low until the first load.
- R2: A `start` taken while idle loads the vectors on that clock edge. In the next cycle, `lam_out` equals `phi_in`, `lamt_out` equals the constant polynomial 1 (coefficient 0 equal to 1, all others 0), `dlt_out` equals `psi_in` and `dls_out` equals `syn_in`. Coefficient i of every vector sits at bits `[i*M +: M]`.
- R3: Exactly `2*BETA` update edges follow the load edge. `done` is high for exactly one cycle, the cycle right after the last update edge.
- R4: Each iteration sets tilde and starred discrepancy coefficient i to `gamma*d(i+1) xor d0*theta(i)`, where each vector uses its own auxiliary, and d(T2) is taken as zero.
- R5: Each iteration sets locator coefficient i (main and tilde) to `gamma*lambda(i) xor d0*b(i-1)`, where each locator uses its own auxiliary and b(-1) is zero.
- R6: When `d0` is nonzero and `k >= 0`, the iteration swaps. Each locator auxiliary takes the old locator. Each discrepancy auxiliary takes the old discrepancy vector moved down one place (theta(i) = old d(i+1), top entry 0). `gamma` takes `d0`, and `k` becomes `-k-1`.
- R7: In any other case, each locator auxiliary moves up one degree with a zero entering at degree 0. The discrepancy auxiliaries and `gamma` keep their values, and `k` increases by one.
- R8: Field products use GF(2^3) with the primitive polynomial x^3+x+1 (alpha^3 = alpha+1). Addition and subtraction are bitwise XOR.
- R9: A `start` raised while an iteration run is in progress is ignored. The run in progress completes with its own data and gives a single `done`.
- R10: While idle with `start` low, all four output vectors stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the initial vectors and begin a run |
| phi_in | input | (T2-1)*M | Scaled locator seed, coefficient i at [i*M +: M] |
| psi_in | input | T2*M | Modified-syndrome polynomial |
| syn_in | input | T2*M | Raw syndromes |
| lam_out | output | (T2-1)*M | Main locator candidate |
| lamt_out | output | (T2-1)*M | Tilde locator candidate |
| dlt_out | output | T2*M | Tilde discrepancy / evaluator vector |
| dls_out | output | T2*M | Starred discrepancy vector |
| done | output | 1 | One-cycle pulse after the final iteration |

## Verification
The checker assumes two things about the inputs. First, `start` comes from the surrounding controller on cycle boundaries. Second, `phi_in`, `psi_in` and `syn_in` are only meaningful on the cycle in which `start` is taken, so its load check compares against their value on that edge and nothing else. The bench drives every input at the falling edge. It changes the input vectors only on a cycle that also raises `start`, and it raises a second `start` inside a run solely to show that it is ignored. The bench also issues the next run on the cycle where `done` is high, so an immediate restart is exercised. The expected vectors come from a plain array model of the recurrences, with its own shift-and-reduce multiplier. The vectors cover a zero discrepancy (no swap), a nonzero first discrepancy (swap) and a run of pseudo-random polynomials.

// File: rtl/ikes_pkg.sv
// Shared types for the inversionless key-equation iterator.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package ikes_pkg;

    // Per-cycle commands fanned out from the control unit to every lane.
    typedef struct packed {
        logic load;   // copy initial vectors into the registers
        logic step;   // perform one iteration
        logic swap;   // current iteration takes the swap branch
    } ikes_ctl_t;

endpackage

// File: rtl/gf_mult.sv
// Combinational GF(2^M) multiplier: schoolbook carry-less product followed
// by reduction from the top bit down by the primitive polynomial POLY.
// Assumes: M >= 3 and POLY holds M+1 bits with the x^M term set.
module gf_mult #(
    parameter int          M    = 3,
    parameter logic [M:0]  POLY = 4'b1011
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    localparam int PW = 2*M - 1;

    logic [PW-1:0] prod;

    // Carry-less multiply then modular reduction.
    always_comb begin
        prod = '0;
        for (int i = 0; i < M; i++) begin
            if (b[i]) prod = prod ^ ({{(M-1){1'b0}}, a} << i);
        end
        for (int j = PW-1; j >= M; j--) begin
            if (prod[j]) prod = prod ^ ({{(PW-M-1){1'b0}}, POLY} << (j-M));
        end
    end

    assign p = prod[M-1:0];
endmodule

// File: rtl/ikes_loc_lane.sv
// One locator pair: a locator vector and its auxiliary vector.
// Each step: lambda(i) <= gamma*lambda(i) ^ d0*b(i-1); the auxiliary either
// copies the old locator (swap) or moves up one degree with zero at the bottom.
// Assumes: load and step are never high together.
module ikes_loc_lane
    import ikes_pkg::*;
#(
    parameter int         M    = 3,
    parameter int         N    = 3,
    parameter logic [M:0] POLY = 4'b1011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ikes_ctl_t      ctl,
    input  logic [M-1:0]   gamma,
    input  logic [M-1:0]   d0,
    input  logic [N*M-1:0] init_a,
    input  logic [N*M-1:0] init_b,
    output logic [N*M-1:0] a_out
);
    logic [M-1:0] a_q   [N];
    logic [M-1:0] b_q   [N];
    logic [M-1:0] b_dn  [N];
    logic [M-1:0] ga    [N];
    logic [M-1:0] db    [N];

    for (genvar i = 0; i < N; i++) begin : g_coef
        if (i == 0) begin : g_low
            assign b_dn[i] = '0;
        end else begin : g_up
            assign b_dn[i] = b_q[i-1];
        end

        gf_mult #(.M(M), .POLY(POLY)) u_ga (.a(gamma), .b(a_q[i]),  .p(ga[i]));
        gf_mult #(.M(M), .POLY(POLY)) u_db (.a(d0),    .b(b_dn[i]), .p(db[i]));

        // Coefficient i of the locator and of its auxiliary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q[i] <= '0;
                b_q[i] <= '0;
            end else if (ctl.load) begin
                a_q[i] <= init_a[i*M +: M];
                b_q[i] <= init_b[i*M +: M];
            end else if (ctl.step) begin
                a_q[i] <= ga[i] ^ db[i];
                b_q[i] <= ctl.swap ? a_q[i] : b_dn[i];
            end
        end

        assign a_out[i*M +: M] = a_q[i];
    end
endmodule

// File: rtl/ikes_disc_lane.sv
// One discrepancy pair: a discrepancy vector and its auxiliary vector.
// Each step: d(i) <= gamma*d(i+1) ^ d0*theta(i); on swap the auxiliary takes
// the old vector moved down one place, otherwise it holds.
// Assumes: load and step are never high together; d(N) is zero.
module ikes_disc_lane
    import ikes_pkg::*;
#(
    parameter int         M    = 3,
    parameter int         N    = 4,
    parameter logic [M:0] POLY = 4'b1011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ikes_ctl_t      ctl,
    input  logic [M-1:0]   gamma,
    input  logic [M-1:0]   d0,
    input  logic [N*M-1:0] init_v,
    output logic [N*M-1:0] d_out
);
    logic [M-1:0] d_q   [N];
    logic [M-1:0] t_q   [N];
    logic [M-1:0] d_nx  [N];
    logic [M-1:0] gd    [N];
    logic [M-1:0] dt    [N];

    for (genvar i = 0; i < N; i++) begin : g_coef
        if (i == N-1) begin : g_top
            assign d_nx[i] = '0;
        end else begin : g_mid
            assign d_nx[i] = d_q[i+1];
        end

        gf_mult #(.M(M), .POLY(POLY)) u_gd (.a(gamma), .b(d_nx[i]), .p(gd[i]));
        gf_mult #(.M(M), .POLY(POLY)) u_dt (.a(d0),    .b(t_q[i]),  .p(dt[i]));

        // Coefficient i of the discrepancy vector and of its auxiliary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q[i] <= '0;
                t_q[i] <= '0;
            end else if (ctl.load) begin
                d_q[i] <= init_v[i*M +: M];
                t_q[i] <= init_v[i*M +: M];
            end else if (ctl.step) begin
                d_q[i] <= gd[i] ^ dt[i];
                if (ctl.swap) t_q[i] <= d_nx[i];
            end
        end

        assign d_out[i*M +: M] = d_q[i];
    end
endmodule

// File: rtl/ikes_ctrl.sv
// Run control: iteration counter, scalar gamma, signed counter k, swap
// decision and the done pulse.
// Assumes: start is ignored while a run is in progress; NITER >= 1.
module ikes_ctrl
    import ikes_pkg::*;
#(
    parameter int M     = 3,
    parameter int NITER = 2,
    parameter int KW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [M-1:0]         d0,
    output ikes_ctl_t            ctl,
    output logic [M-1:0]         gamma,
    output logic signed [KW-1:0] k_q,
    output logic                 busy,
    output logic                 done
);
    localparam int CW = $clog2(NITER + 1);
    localparam logic [CW-1:0] LAST = CW'(NITER - 1);
    localparam logic signed [KW-1:0] K_ONE = 1;

    logic [CW-1:0] cnt;

    // Decode the per-cycle commands.
    always_comb begin
        ctl.load = start && !busy;
        ctl.step = busy;
        ctl.swap = busy && (d0 != '0) && !k_q[KW-1];
    end

    // Sequence the run and update gamma and k.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            gamma <= '0;
            k_q   <= '0;
        end else begin
            done <= 1'b0;
            if (ctl.load) begin
                busy  <= 1'b1;
                cnt   <= '0;
                gamma <= M'(1);
                k_q   <= '0;
            end else if (busy) begin
                if (ctl.swap) begin
                    gamma <= d0;
                    k_q   <= -k_q - K_ONE;
                end else begin
                    k_q   <= k_q + K_ONE;
                end
                cnt <= cnt + CW'(1);
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ikes_iter.sv
// Top of the inversionless key-equation iterator: one control unit, two
// locator lanes and two discrepancy lanes stepping in lockstep for 2*BETA
// cycles per run.
// Assumes: 2*BETA <= T2 so k stays inside its signed range.
module ikes_iter
    import ikes_pkg::*;
#(
    parameter int         M     = 3,
    parameter int         T2    = 4,
    parameter int         BETA  = 1,
    parameter logic [M:0] POLY  = 4'b1011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [(T2-1)*M-1:0]  phi_in,
    input  logic [T2*M-1:0]      psi_in,
    input  logic [T2*M-1:0]      syn_in,
    output logic [(T2-1)*M-1:0]  lam_out,
    output logic [(T2-1)*M-1:0]  lamt_out,
    output logic [T2*M-1:0]      dlt_out,
    output logic [T2*M-1:0]      dls_out,
    output logic                 done
);
    localparam int LN    = T2 - 1;
    localparam int NITER = 2 * BETA;
    localparam int KW    = $clog2(T2) + 2;
    localparam logic [LN*M-1:0] ONE_VEC = {{(LN*M-1){1'b0}}, 1'b1};

    ikes_ctl_t             ctl;
    logic [M-1:0]          gamma;
    logic [M-1:0]          d0;
    logic signed [KW-1:0]  k_cur;
    logic                  busy;
    logic                  swap_now;

    assign d0       = dlt_out[M-1:0];
    assign swap_now = ctl.swap;

    ikes_ctrl #(.M(M), .NITER(NITER), .KW(KW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .d0(d0),
        .ctl(ctl), .gamma(gamma), .k_q(k_cur), .busy(busy), .done(done)
    );

    ikes_loc_lane #(.M(M), .N(LN), .POLY(POLY)) u_loc_main (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .gamma(gamma), .d0(d0),
        .init_a(phi_in), .init_b(phi_in), .a_out(lam_out)
    );

    ikes_loc_lane #(.M(M), .N(LN), .POLY(POLY)) u_loc_tilde (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .gamma(gamma), .d0(d0),
        .init_a(ONE_VEC), .init_b(ONE_VEC), .a_out(lamt_out)
    );

    ikes_disc_lane #(.M(M), .N(T2), .POLY(POLY)) u_disc_tilde (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .gamma(gamma), .d0(d0),
        .init_v(psi_in), .d_out(dlt_out)
    );

    ikes_disc_lane #(.M(M), .N(T2), .POLY(POLY)) u_disc_star (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .gamma(gamma), .d0(d0),
        .init_v(syn_in), .d_out(dls_out)
    );
endmodule

// File: rtl/ikes_iter_chk.sv
// Property checker for ikes_iter, attached by bind. Counts update edges
// since the last load to check the run length without deep $past.
// Assumes: clocked by the same clock and reset as the iterator.
module ikes_iter_chk #(
    parameter int M     = 3,
    parameter int T2    = 4,
    parameter int BETA  = 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic                        swap_now,
    input logic signed [$clog2(T2)+1:0] k_cur,
    input logic                        done,
    input logic [(T2-1)*M-1:0]         phi_in,
    input logic [T2*M-1:0]             psi_in,
    input logic [T2*M-1:0]             syn_in,
    input logic [(T2-1)*M-1:0]         lam_out,
    input logic [(T2-1)*M-1:0]         lamt_out,
    input logic [T2*M-1:0]             dlt_out,
    input logic [T2*M-1:0]             dls_out
);
    localparam int NITER = 2 * BETA;
    localparam int UW    = $clog2(NITER + 1) + 1;
    localparam int KW    = $clog2(T2) + 2;
    localparam logic [(T2-1)*M-1:0] ONE_VEC = {{((T2-1)*M-1){1'b0}}, 1'b1};
    localparam logic signed [KW-1:0] K_ONE = 1;

    logic [UW-1:0] upd;

    // Count update edges since the most recent load.
    always_ff @(posedge clk) begin
        if (!rst_n)                upd <= '0;
        else if (start && !busy)   upd <= '0;
        else if (busy)             upd <= upd + UW'(1);
    end

    // R3
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (upd == UW'(NITER) && !busy));

    // R2
    load_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (lam_out == $past(phi_in) && lamt_out == ONE_VEC &&
                              dlt_out == $past(psi_in) && dls_out == $past(syn_in)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lam_out) && $stable(lamt_out) &&
                               $stable(dlt_out) && $stable(dls_out)));

    // R6
    swap_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && swap_now) |=> k_cur[KW-1]);

    // R7
    noswap_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !swap_now) |=> (k_cur == $past(k_cur) + K_ONE));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && upd != UW'(NITER - 1)) |=> busy);
endmodule

bind ikes_iter ikes_iter_chk #(.M(M), .T2(T2), .BETA(BETA)) u_ikes_iter_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .swap_now(swap_now),
    .k_cur(k_cur), .done(done), .phi_in(phi_in), .psi_in(psi_in), .syn_in(syn_in),
    .lam_out(lam_out), .lamt_out(lamt_out), .dlt_out(dlt_out), .dls_out(dls_out)
);

// File: tb/ikes_iter_bench.sv
module ikes_iter_bench;
    localparam int M     = 3;
    localparam int T2    = 4;
    localparam int BETA  = 1;
    localparam int NITER = 2 * BETA;
    localparam int LN    = T2 - 1;
    localparam int DN    = T2;

    typedef struct {
        logic [LN*M-1:0] lam;
        logic [LN*M-1:0] lamt;
        logic [DN*M-1:0] dl;
        logic [DN*M-1:0] ds;
        int              when;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [LN*M-1:0]     phi_in = '0;
    logic [DN*M-1:0]     psi_in = '0;
    logic [DN*M-1:0]     syn_in = '0;
    logic [LN*M-1:0]     lam_out, lamt_out;
    logic [DN*M-1:0]     dlt_out, dls_out;
    logic                done;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   ended = 1'b0;
    exp_t q[$];
    exp_t last;
    int unsigned seed = 32'h1F2E3D4C;

    ikes_iter #(.M(M), .T2(T2), .BETA(BETA)) u_ikes_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .phi_in(phi_in), .psi_in(psi_in),
        .syn_in(syn_in), .lam_out(lam_out), .lamt_out(lamt_out), .dlt_out(dlt_out),
        .dls_out(dls_out), .done(done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // R8: shift-and-add multiply, alpha^3 = alpha + 1
    function automatic logic [2:0] gm(logic [2:0] a, logic [2:0] b);
        logic [2:0] r = '0;
        logic [2:0] x = a;
        for (int i = 0; i < 3; i++) begin
            if (b[i]) r = r ^ x;
            x = x[2] ? ((x << 1) ^ 3'b011) : (x << 1);
        end
        return r;
    endfunction

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Array model of R4-R7 over 2*BETA iterations
    task automatic model(input logic [LN*M-1:0] phi, input logic [DN*M-1:0] psi,
                         input logic [DN*M-1:0] syn, output exp_t e);
        logic [2:0] lam[LN], b[LN], lt[LN], bt[LN], d[DN], th[DN], ds[DN], ths[DN];
        logic [2:0] nl[LN], nlt[LN], nd[DN], nds[DN];
        logic [2:0] g, d0, dp, dsp;
        int k;
        for (int i = 0; i < LN; i++) begin
            lam[i] = phi[i*M +: M]; b[i] = lam[i];
            lt[i] = (i == 0) ? 3'd1 : 3'd0; bt[i] = lt[i];
        end
        for (int i = 0; i < DN; i++) begin
            d[i] = psi[i*M +: M]; th[i] = d[i];
            ds[i] = syn[i*M +: M]; ths[i] = ds[i];
        end
        g = 3'd1; k = 0;
        for (int r = 0; r < NITER; r++) begin
            d0 = d[0];
            for (int i = 0; i < DN; i++) begin
                dp  = (i + 1 < DN) ? d[i+1]  : 3'd0;
                dsp = (i + 1 < DN) ? ds[i+1] : 3'd0;
                nd[i]  = gm(g, dp)  ^ gm(d0, th[i]);
                nds[i] = gm(g, dsp) ^ gm(d0, ths[i]);
            end
            for (int i = 0; i < LN; i++) begin
                nl[i]  = gm(g, lam[i]) ^ gm(d0, (i > 0) ? b[i-1]  : 3'd0);
                nlt[i] = gm(g, lt[i])  ^ gm(d0, (i > 0) ? bt[i-1] : 3'd0);
            end
            if (d0 != 0 && k >= 0) begin
                for (int i = 0; i < LN; i++) begin b[i] = lam[i]; bt[i] = lt[i]; end
                for (int i = 0; i < DN; i++) begin
                    th[i]  = (i + 1 < DN) ? d[i+1]  : 3'd0;
                    ths[i] = (i + 1 < DN) ? ds[i+1] : 3'd0;
                end
                g = d0; k = -k - 1;
            end else begin
                for (int i = LN-1; i > 0; i--) begin b[i] = b[i-1]; bt[i] = bt[i-1]; end
                b[0] = 3'd0; bt[0] = 3'd0;
                k = k + 1;
            end
            lam = nl; lt = nlt; d = nd; ds = nds;
        end
        for (int i = 0; i < LN; i++) begin
            e.lam[i*M +: M] = lam[i]; e.lamt[i*M +: M] = lt[i];
        end
        for (int i = 0; i < DN; i++) begin
            e.dl[i*M +: M] = d[i]; e.ds[i*M +: M] = ds[i];
        end
    endtask

    // Driver: start one run, push its expectation, check the load (R2)
    task automatic issue(input logic [LN*M-1:0] phi, input logic [DN*M-1:0] psi,
                         input logic [DN*M-1:0] syn, input bit poke_busy);
        exp_t e;
        @(negedge clk);
        phi_in = phi; psi_in = psi; syn_in = syn; start = 1'b1;
        model(phi, psi, syn, e);
        e.when = cyc + 1 + NITER;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check("R2", "load lam", 32'(lam_out), 32'(phi));
        check("R2", "load lamt", 32'(lamt_out), 32'd1);
        check("R2", "load dlt", 32'(dlt_out), 32'(psi));
        check("R2", "load dls", 32'(dls_out), 32'(syn));
        if (poke_busy) begin
            // R9: second start inside the run must be ignored
            phi_in = ~phi; psi_in = ~psi; syn_in = ~syn; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (NITER + 1) @(negedge clk);
        end else begin
            repeat (NITER - 1) @(negedge clk);
        end
    endtask

    // Monitor: on each done, pop and compare (R3 timing, R4-R7 values)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected done: actual 1 expected 0");
            end else begin
                last = q.pop_front();
                check("R3", "done cycle", 32'(cyc), 32'(last.when));
                check("R5", "lam", 32'(lam_out), 32'(last.lam));
                check("R5", "lamt", 32'(lamt_out), 32'(last.lamt));
                check("R4", "dlt", 32'(dlt_out), 32'(last.dl));
                check("R4", "dls", 32'(dls_out), 32'(last.ds));
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "lam reset", 32'(lam_out), 32'd0);
        check("R1", "dlt reset", 32'(dlt_out), 32'd0);
        check("R1", "done reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "done after release", 32'(done), 32'd0);
        check("R1", "lamt after release", 32'(lamt_out), 32'd0);

        // R7: zero discrepancy, no swap in any iteration
        issue(9'o765, '0, 12'o1234, 1'b0);
        // R6: nonzero first discrepancy forces a swap
        issue(9'o123, 12'o0005, 12'o7351, 1'b0);
        // R8: all-ones field elements stress the reduction
        issue(9'o777, 12'o7777, 12'o7777, 1'b0);
        // R4 R5: pseudo-random polynomials, back to back
        for (int n = 0; n < 14; n++) begin
            issue(9'(rnd()), 12'(rnd()), 12'(rnd()), 1'b0);
        end
        // R9: start while busy
        issue(9'o246, 12'o3157, 12'o6420, 1'b1);

        // R10: outputs hold while idle
        repeat (5) @(negedge clk);
        check("R10", "hold lam", 32'(lam_out), 32'(last.lam));
        check("R10", "hold lamt", 32'(lamt_out), 32'(last.lamt));
        check("R10", "hold dlt", 32'(dlt_out), 32'(last.dl));
        check("R10", "hold dls", 32'(dls_out), 32'(last.ds));
        check("R3", "pending runs", 32'(q.size()), 32'd0);
        finish_run();
    end
endmodule